// File: doc/BRIEF.md
# Time-Frequency Correlator Combiner

This block turns one grid of received time-frequency coefficients into a single complex decision statistic for one data symbol. For every cell of the grid it takes three complex samples, all streamed together: the received coefficient `c`, the single-tap channel estimate `h` for that cell, and the reference-waveform coefficient `u`. It forms the product `c * conj(h) * conj(u)` and adds it into a running sum. The sum covers every cell from the first cell after a last-cell flag up to and including the next flagged cell. The order of cells inside a grid has no effect on the result, so any time-by-frequency scan works. A scan with frequency as the fastest-changing index is the intended one.

A per-cell mode input selects the weighting. Maximal-ratio weighting adds the product directly. Zero-forcing divides it by the channel power `|h|^2`. MMSE divides it by `|h|^2 + N0`, where `N0` is a programmable noise level. Both division modes run through a bit-serial divider that takes many cycles. While the divider runs, the block holds the input back with a ready signal. A cell whose divisor is zero adds nothing and raises a sticky flag.

The result leaves through a single-cycle strobe that carries the saturated real and imaginary parts.

Top module: `tf_combiner`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `zero_div_flag` is 0.
- R2: For mode 0 (maximal ratio), each cell adds `q >>> 15` to the sum, separately for the real and imaginary parts. Here `q = c*conj(h)*conj(u)` is computed exactly and the shift is an arithmetic shift that rounds toward minus infinity.
- R3: For mode 1 (zero-forcing), each cell adds `q / (h_re^2 + h_im^2)` to each component, with the quotient truncated toward zero.
- R4: For mode 2 (MMSE), the divisor is `h_re^2 + h_im^2 + noise_n0`, with `noise_n0` read as unsigned. Truncation is toward zero as in R3.
- R5: In modes 1 and 2, a cell whose divisor is zero adds zero, does not stall the input, and sets `zero_div_flag`. The flag then stays at 1 until reset. A zero channel with a nonzero `noise_n0` does not set the flag.
- R6: When a mode 1 or mode 2 cell with a nonzero divisor is accepted, `in_ready` is 0 for exactly 49 cycles, starting with the cycle after acceptance. Mode 0 and mode 3 cells and zero-divisor cells never lower `in_ready`.
- R7: The first cell accepted after reset, or after a cell with `in_last` set, starts a new sum. Earlier grids have no effect on it, and a single cell may form a whole grid.
- R8: `out_valid` is a one-cycle pulse. It rises in the cycle after the term of the flagged last cell is added. For a mode 0 cell that term is added at the accepting edge. For a dividing cell it is added on the edge that raises `in_ready` again.
- R9: The running sum is a 40-bit value that saturates at its limits and does not wrap. `out_re` and `out_im` are that sum saturated to signed 32 bits.
- R10: Mode 3 weights a cell exactly as mode 0 does. The mode may change from cell to cell within one grid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Weighting of the presented cell: 0/3 maximal ratio, 1 zero-forcing, 2 MMSE |
| noise_n0 | input | 32 | Unsigned noise term added to the MMSE divisor |
| in_valid | input | 1 | A cell is presented |
| in_ready | output | 1 | The block can accept a cell this cycle |
| in_last | input | 1 | The presented cell closes the grid |
| c_re | input | 16 | Received coefficient, real, signed |
| c_im | input | 16 | Received coefficient, imaginary, signed |
| h_re | input | 16 | Channel tap, real, signed |
| h_im | input | 16 | Channel tap, imaginary, signed |
| u_re | input | 16 | Reference coefficient, real, signed |
| u_im | input | 16 | Reference coefficient, imaginary, signed |
| out_valid | output | 1 | One-cycle strobe for a finished statistic |
| out_re | output | 32 | Statistic, real, signed, saturated |
| out_im | output | 32 | Statistic, imaginary, signed, saturated |
| zero_div_flag | output | 1 | Sticky: a dividing cell had a zero divisor |

## Verification
The result of a maximal-ratio or zero-divisor cell enters the sum at the edge that accepts the cell. For such a last cell the strobe is due one cycle later. A dividing cell keeps `in_ready` low for 49 cycles, and its strobe follows one cycle after `in_ready` returns. The bench samples every port at falling edges. After each accepted cell it counts the low cycles of `in_ready` and compares the count with 0 or 49. It then looks for the strobe absent at the first sample, present at the next, and gone at the one after, and reads the data in the present cycle. The expected sums come from an exact model of the weighting written with 64-bit integers, with 40-bit and then 32-bit saturation applied.

// File: rtl/tf_combiner.sv
module tf_combiner #(
  parameter int DW   = 16,
  parameter int AW   = 40,
  parameter int OW   = 32,
  parameter int NW   = 32,
  parameter int FRAC = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic [NW-1:0]        noise_n0,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_last,
  input  logic signed [DW-1:0] c_re,
  input  logic signed [DW-1:0] c_im,
  input  logic signed [DW-1:0] h_re,
  input  logic signed [DW-1:0] h_im,
  input  logic signed [DW-1:0] u_re,
  input  logic signed [DW-1:0] u_im,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_re,
  output logic signed [OW-1:0] out_im,
  output logic                 zero_div_flag
);
  localparam int PW  = 2*DW + 1;
  localparam int QW  = PW + DW + 1;
  localparam int MW  = QW - 2;
  localparam int DVW = ((2*DW > NW) ? 2*DW : NW) + 2;
  localparam int CW  = $clog2(MW);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_ADD} state_t;
  state_t state;

  logic signed [PW-1:0]   p_re, p_im;
  logic signed [QW-1:0]   q_re, q_im;
  logic signed [2*DW+1:0] hpow;
  logic [DVW-1:0]         dvs, dvsr;
  logic [MW-1:0]          dq [2];
  logic [DVW-1:0]         rem [2];
  logic [DVW-1:0]         rem_nx [2];
  logic [1:0]             qbit;
  logic                   neg_re, neg_im, last_q, fresh, done;
  logic [CW-1:0]          cnt;
  logic signed [AW-1:0]   acc_re, acc_im, add_re, add_im, base_re, base_im;
  logic                   fire, div_mode, zdiv, add_en, add_last;

  assign p_re = c_re*h_re + c_im*h_im;
  assign p_im = c_im*h_re - c_re*h_im;
  assign q_re = p_re*u_re + p_im*u_im;
  assign q_im = p_im*u_re - p_re*u_im;
  assign hpow = h_re*h_re + h_im*h_im;
  assign dvs  = DVW'(hpow) + ((mode == 2'd2) ? DVW'(noise_n0) : '0);

  assign in_ready = (state == S_IDLE);
  assign fire     = in_valid && in_ready;
  assign div_mode = (mode == 2'd1) || (mode == 2'd2);
  assign zdiv     = div_mode && (dvs == '0);

  assign add_en   = (state == S_ADD) || (fire && !(div_mode && !zdiv));
  assign add_last = (state == S_ADD) ? last_q : in_last;
  assign add_re   = (state == S_ADD) ? (neg_re ? -AW'(dq[0]) : AW'(dq[0]))
                  : (div_mode ? '0 : AW'(q_re >>> FRAC));
  assign add_im   = (state == S_ADD) ? (neg_im ? -AW'(dq[1]) : AW'(dq[1]))
                  : (div_mode ? '0 : AW'(q_im >>> FRAC));
  assign base_re  = fresh ? '0 : acc_re;
  assign base_im  = fresh ? '0 : acc_im;

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      logic [DVW-1:0] trial;
      trial = {rem[k][DVW-2:0], dq[k][MW-1]};
      if (trial >= dvsr) begin
        rem_nx[k] = trial - dvsr;
        qbit[k]   = 1'b1;
      end else begin
        rem_nx[k] = trial;
        qbit[k]   = 1'b0;
      end
    end
  end

  function automatic logic signed [AW-1:0] sat_add(input logic signed [AW-1:0] a,
                                                   input logic signed [AW-1:0] b);
    logic [AW:0] s;
    s = {a[AW-1], a} + {b[AW-1], b};
    if (s[AW] != s[AW-1])
      return s[AW] ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}};
    return s[AW-1:0];
  endfunction

  function automatic logic signed [OW-1:0] sat_out(input logic signed [AW-1:0] a);
    if ((&a[AW-1:OW-1]) || !(|a[AW-1:OW-1]))
      return a[OW-1:0];
    return a[AW-1] ? {1'b1, {(OW-1){1'b0}}} : {1'b0, {(OW-1){1'b1}}};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      cnt           <= '0;
      dvsr          <= '0;
      dq[0]         <= '0;
      dq[1]         <= '0;
      rem[0]        <= '0;
      rem[1]        <= '0;
      neg_re        <= 1'b0;
      neg_im        <= 1'b0;
      last_q        <= 1'b0;
      fresh         <= 1'b1;
      done          <= 1'b0;
      acc_re        <= '0;
      acc_im        <= '0;
      out_valid     <= 1'b0;
      out_re        <= '0;
      out_im        <= '0;
      zero_div_flag <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (fire && div_mode && !zdiv) begin
          state  <= S_DIV;
          cnt    <= '0;
          dvsr   <= dvs;
          last_q <= in_last;
          neg_re <= q_re[QW-1];
          neg_im <= q_im[QW-1];
          dq[0]  <= MW'(q_re[QW-1] ? -q_re : q_re);
          dq[1]  <= MW'(q_im[QW-1] ? -q_im : q_im);
          rem[0] <= '0;
          rem[1] <= '0;
        end
        S_DIV: begin
          for (int k = 0; k < 2; k++) begin
            rem[k] <= rem_nx[k];
            dq[k]  <= {dq[k][MW-2:0], qbit[k]};
          end
          cnt <= cnt + 1'b1;
          if (cnt == CW'(MW-1)) state <= S_ADD;
        end
        default: state <= S_IDLE;
      endcase
      if (add_en) begin
        acc_re <= sat_add(base_re, add_re);
        acc_im <= sat_add(base_im, add_im);
        fresh  <= add_last;
      end
      done      <= add_en && add_last;
      out_valid <= done;
      if (done) begin
        out_re <= sat_out(acc_re);
        out_im <= sat_out(acc_im);
      end
      if (fire && zdiv) zero_div_flag <= 1'b1;
    end
  end

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_div_flag |=> zero_div_flag);
  assert_zero_div_no_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && zdiv) |=> in_ready);
  assert_divide_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && div_mode && !zdiv) |=> !in_ready);
  assert_acc_frozen_in_divide_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DIV) |=> ($stable(acc_re) && $stable(acc_im)));
  assert_strobe_follows_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(done));
endmodule

// File: tb/tf_combiner_bench.sv
`timescale 1ns/1ps
module tf_combiner_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = '0;
  logic [31:0] noise_n0 = '0;
  logic in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic signed [15:0] c_re = '0, c_im = '0, h_re = '0, h_im = '0, u_re = '0, u_im = '0;
  logic out_valid, zero_div_flag;
  logic signed [31:0] out_re, out_im;

  int tests = 0, fails = 0;
  longint er = 0, ei = 0;
  bit fresh_m = 1'b1, flag_m = 1'b0;
  int stall;

  always #2.5 clk = ~clk;

  tf_combiner u_tf_combiner (
    .clk(clk), .rst_n(rst_n), .mode(mode), .noise_n0(noise_n0),
    .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
    .c_re(c_re), .c_im(c_im), .h_re(h_re), .h_im(h_im), .u_re(u_re), .u_im(u_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .zero_div_flag(zero_div_flag)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v, input int bits);
    longint hi = (longint'(1) <<< (bits-1)) - 1;
    longint lo = -(longint'(1) <<< (bits-1));
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  task automatic model_term(input int md, cr, ci, hr, hi, ur, ui,
                            output longint tr, output longint ti);
    longint pr = longint'(cr)*hr + longint'(ci)*hi;
    longint pi = longint'(ci)*hr - longint'(cr)*hi;
    longint qr = pr*ur + pi*ui;
    longint qi = pi*ur - pr*ui;
    longint d;
    if (md == 1 || md == 2) begin
      d = longint'(hr)*hr + longint'(hi)*hi + ((md == 2) ? longint'(noise_n0) : 0);
      if (d == 0) begin
        tr = 0; ti = 0; flag_m = 1'b1;
      end else begin
        tr = qr / d; ti = qi / d;
      end
    end else begin
      tr = qr >>> 15; ti = qi >>> 15;
    end
  endtask

  task automatic send_cell(input int md, cr, ci, hr, hi, ur, ui, input bit last,
                           output int stl);
    longint tr, ti;
    @(negedge clk);
    mode = 2'(md); c_re = 16'(cr); c_im = 16'(ci); h_re = 16'(hr); h_im = 16'(hi);
    u_re = 16'(ur); u_im = 16'(ui); in_valid = 1'b1; in_last = last;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    model_term(md, cr, ci, hr, hi, ur, ui, tr, ti);
    if (fresh_m) begin er = 0; ei = 0; end
    er = sat(er + tr, 40); ei = sat(ei + ti, 40);
    fresh_m = last;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    stl = 0;
    while (!in_ready) begin stl++; @(negedge clk); end
  endtask

  task automatic finish_grid(input string req);
    check(out_valid == 1'b0, {req, " R8 strobe early"}, out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, {req, " R8 strobe"}, out_valid, 1);
    check(out_re == sat(er, 32), {req, " re"}, out_re, sat(er, 32));
    check(out_im == sat(ei, 32), {req, " im"}, out_im, sat(ei, 32));
    @(negedge clk);
    check(out_valid == 1'b0, {req, " R8 pulse width"}, out_valid, 0);
  endtask

  task automatic t_reset;
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(zero_div_flag == 1'b0, "R1 flag", zero_div_flag, 0);
  endtask

  task automatic t_mrc(input int md, input string req);
    int v [6][6] = '{'{1200,-300,5000,200,-700,900}, '{-32768,32767,100,-100,2000,2000},
                     '{15,-9,30000,-25000,32767,-32768}, '{0,0,1,1,1,1},
                     '{-4000,-4000,-4000,4000,300,-300}, '{7,8,9,10,11,12}};
    for (int i = 0; i < 6; i++) begin
      send_cell(md, v[i][0], v[i][1], v[i][2], v[i][3], v[i][4], v[i][5], i == 5, stall);
      check(stall == 0, {req, " R6 no stall"}, stall, 0);
    end
    finish_grid(req);
  endtask

  task automatic t_zf;
    send_cell(1, 1000, -2000, 300, 400, 1500, 700, 1'b0, stall);
    check(stall == 49, "R6 zf stall", stall, 49);
    send_cell(1, -32768, 12345, 1, 0, 32767, -32768, 1'b0, stall);
    check(stall == 49, "R6 zf stall small h", stall, 49);
    send_cell(1, 777, 555, -9000, 3, -20000, 4321, 1'b1, stall);
    check(stall == 49, "R6 zf stall last", stall, 49);
    finish_grid("R3 zf");
  endtask

  task automatic t_mmse;
    noise_n0 = 32'd5000;
    send_cell(2, 1000, -2000, 30, 40, 1500, 700, 1'b0, stall);
    check(stall == 49, "R6 mmse stall", stall, 49);
    send_cell(2, 3000, 3000, 0, 0, 100, 100, 1'b0, stall);
    check(stall == 49, "R6 mmse zero h nonzero n0", stall, 49);
    send_cell(2, -25000, 400, -120, 77, 900, -31000, 1'b1, stall);
    finish_grid("R4 mmse");
    check(zero_div_flag == 1'b0, "R5 flag clear with n0", zero_div_flag, 0);
    noise_n0 = 32'd0;
  endtask

  task automatic t_mixed;
    send_cell(0, 2222, -1111, 800, 900, -700, 600, 1'b0, stall);
    send_cell(1, 5000, 4000, 70, -80, 9000, 100, 1'b0, stall);
    send_cell(3, -3000, 2000, 1000, -1000, 500, 500, 1'b1, stall);
    finish_grid("R10 mixed modes");
  endtask

  task automatic t_restart;
    send_cell(0, 30000, 30000, 30000, -30000, 30000, 1, 1'b0, stall);
    send_cell(0, 1234, 4321, 555, 666, 777, 888, 1'b1, stall);
    finish_grid("R7 grid A");
    send_cell(0, -10, 20, 30, -40, 50, 60, 1'b1, stall);
    finish_grid("R7 single cell");
    send_cell(1, 400, 500, 10, 20, 30, 40, 1'b0, stall);
    send_cell(0, 9, 8, 7, 6, 5, 4, 1'b1, stall);
    finish_grid("R7 grid C");
  endtask

  task automatic t_zero;
    send_cell(0, 100, 200, 300, 400, 500, 600, 1'b0, stall);
    send_cell(1, 32767, 32767, 0, 0, 32767, 32767, 1'b0, stall);
    check(stall == 0, "R5 zero divisor no stall", stall, 0);
    check(zero_div_flag == 1'b1, "R5 flag set", zero_div_flag, 1);
    send_cell(0, -100, 50, 60, 70, 80, 90, 1'b1, stall);
    finish_grid("R5 zero term");
    send_cell(0, 1, 2, 3, 4, 5, 6, 1'b1, stall);
    finish_grid("R5 later grid");
    check(zero_div_flag == 1'b1, "R5 flag sticky", zero_div_flag, 1);
  endtask

  task automatic t_sat;
    for (int i = 0; i < 3; i++)
      send_cell(0, 32767, 0, 32767, 0, 32767, 0, i == 2, stall);
    finish_grid("R9 out saturation positive");
    check(out_re == 32'sh7fffffff, "R9 out max", out_re, 32'sh7fffffff);
    for (int i = 0; i < 300; i++)
      send_cell(0, -32768, -32768, -32768, -32768, -32768, 0, i == 299, stall);
    finish_grid("R9 acc saturation negative");
    check(out_re == -32'sh80000000, "R9 acc no wrap", out_re, -64'sh80000000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mrc(0, "R2 mrc");
    t_mrc(3, "R10 mode3");
    t_zf();
    t_mmse();
    t_mixed();
    t_restart();
    t_zero();
    t_sat();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule